// File: doc/BRIEF.md
# Power Mode and Frequency-Change Sequencer

This controller moves a processor core between four operating modes: turbo, run, idle and sleep. It also steps through a safe frequency change. Software writes a mode command through a one-cycle request strobe. Wake and interrupt events, a memory-controller acknowledge and a PLL lock indication then drive the state machine. In return the block produces:

- the core clock enable;
- the turbo/run frequency select;
- the PLL configuration word;
- the memory hold and self-refresh requests;
- the power-down output;
- a stretched reset request.

A frequency change follows a fixed order. The controller asks the memory controller to hold external memory and waits for its acknowledge. It then latches the clock configuration word into the PLL configuration output and waits for the PLL to relock. Only after relock does it release memory, so memory contents survive, while peripherals see a pause in data flow. The PLL is modelled inside the block as a lock flag that drops when a new configuration is loaded and rises again a programmable number of cycles later.

Leaving sleep does not resume execution. A wake event raises a reset request of fixed length, and the block comes back in run mode as it would after a reboot. Mode requests that arrive during a frequency change are held and replayed once the sequence completes.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the outputs are:
  - core_clk_en_o = 1, turbo_sel_o = 0 and mode_o = 0 (run);
  - mem_hold_o, mem_sr_o, pwr_down_o, rst_req_o and fc_busy_o all 0;
  - pll_cfg_o = CFG_RST (default 0) and pll_locked_o = 1.
- R2: Command codes on req_cmd_i, taken when req_valid_i is high in the active state: 0 = run, 1 = turbo, 2 = idle, 3 = sleep, 4 = frequency change.
  - Run or turbo sets turbo_sel_o to 0 or 1 one cycle after the request is sampled.
  - Codes 5 to 7 are ignored.
  - Requests sampled in idle, sleep entry, sleep or wake reset are ignored.
- R3: Idle gates the core clock. One cycle after an idle request, core_clk_en_o is 0 and mode_o is 2. An irq_i or wake_i sampled high restores core_clk_en_o = 1 one cycle later, and mode_o returns to the previous run (0) or turbo (1) value.
- R4: A sleep request raises mem_sr_o and sets mode_o to 3 with core_clk_en_o = 0 one cycle later. pwr_down_o rises only after mem_ack_i has been sampled high, and while it is high mem_sr_o is high.
- R5: In sleep, irq_i alone has no effect. wake_i drops pwr_down_o one cycle later and raises rst_req_o for exactly RST_CYC (default 16) consecutive cycles. After that the block is in run mode: mode_o = 0, turbo_sel_o = 0, mem_sr_o = 0, core_clk_en_o = 1.
- R6: A frequency-change request raises fc_busy_o one cycle later, and mem_hold_o one cycle after that. While mem_ack_i stays low, mem_hold_o stays high and pll_cfg_o and pll_locked_o keep their values.
- R7: After the acknowledge is sampled, the next cycle has a gated core clock. In the cycle after that:
  - pll_cfg_o takes the value of cfg_i;
  - pll_locked_o falls and then stays low for exactly lock_dly_i + 1 cycles;
  - core_clk_en_o is 0 throughout the relock.
- R8: One cycle after pll_locked_o rises, fc_busy_o and mem_hold_o fall and core_clk_en_o returns to 1. turbo_sel_o keeps the value it had before the change.
- R9: A valid request sampled while fc_busy_o or the release cycle is active is held, and a later held request replaces an earlier one. The held request takes effect two cycles after fc_busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Mode command strobe |
| req_cmd_i | input | 3 | Mode command code |
| cfg_i | input | CFG_W | Clock configuration word (core and memory frequency settings) |
| lock_dly_i | input | DLY_W | PLL relock delay in cycles |
| irq_i | input | 1 | Enabled interrupt, ends idle |
| wake_i | input | 1 | Wake event, ends idle or sleep |
| mem_ack_i | input | 1 | Memory controller acknowledge for hold or self-refresh |
| core_clk_en_o | output | 1 | Core clock enable |
| turbo_sel_o | output | 1 | 1 selects turbo frequency, 0 run frequency |
| mode_o | output | 2 | 0 run, 1 turbo, 2 idle, 3 sleep |
| pll_cfg_o | output | CFG_W | Configuration word applied to the PLL |
| pll_locked_o | output | 1 | Modelled PLL lock flag |
| mem_hold_o | output | 1 | External memory hold request |
| mem_sr_o | output | 1 | Memory self-refresh request |
| pwr_down_o | output | 1 | Power-domain shutdown |
| rst_req_o | output | 1 | Reset request after sleep wake |
| fc_busy_o | output | 1 | Frequency change in progress |

## Verification
The hardest situation to reach is a request that arrives mid-sequence and must wait. Two competing requests are written while the change is stalled, and the bench checks that only the later one is replayed, two cycles after fc_busy_o falls. The bench controls the memory-acknowledge responder, so it can keep a hold or self-refresh pending for several cycles before letting the sequence continue. With the acknowledge withheld it observes that the PLL word and the power-down output stay put. It then sweeps every relock delay from 0 to 15 and compares the measured low time of pll_locked_o, and the release cycle, with the values computed from the delay.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_RUN   = 3'd0,
    CMD_TURBO = 3'd1,
    CMD_IDLE  = 3'd2,
    CMD_SLEEP = 3'd3,
    CMD_FREQ  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_TURBO = 2'd1,
    MODE_IDLE  = 2'd2,
    MODE_SLEEP = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_ACTIVE,
    ST_IDLE,
    ST_SR_ENTRY,
    ST_SLEEP,
    ST_WAKE_RST,
    ST_FC_REQ,
    ST_FC_HOLD,
    ST_FC_APPLY,
    ST_FC_LOCK,
    ST_FC_REL
  } state_e;
endpackage

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             locked_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b1;
    end else if (start_i) begin
      cnt_q    <= dly_i;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (cnt_q == '0) locked_q <= 1'b1;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign active_o = (cnt_q != '0);
  assign done_o   = (cnt_q == ONE);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_seq_pkg::*;
#(
  parameter int              CFG_W   = 12,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_cmd_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic             mem_ack_i,
  input  logic             pll_locked_i,
  input  logic             stretch_done_i,
  output logic             lock_start_o,
  output logic             stretch_start_o,
  output logic             core_clk_en_o,
  output logic             turbo_sel_o,
  output logic [1:0]       mode_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic             mem_hold_o,
  output logic             mem_sr_o,
  output logic             pwr_down_o,
  output logic             fc_busy_o
);
  state_e           state_q, state_d;
  logic             turbo_q;
  logic             pend_v_q;
  logic [2:0]       pend_cmd_q;
  logic [CFG_W-1:0] cfg_q;

  logic       cmd_ok, in_fc, act_v;
  logic [2:0] act_cmd;

  assign cmd_ok  = req_valid_i && (req_cmd_i <= CMD_FREQ);
  assign in_fc   = state_q inside {ST_FC_REQ, ST_FC_HOLD, ST_FC_APPLY, ST_FC_LOCK, ST_FC_REL};
  // held request has priority over a fresh one in the replay cycle
  assign act_v   = pend_v_q | cmd_ok;
  assign act_cmd = pend_v_q ? pend_cmd_q : req_cmd_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (act_v) begin
        case (act_cmd)
          CMD_IDLE:  state_d = ST_IDLE;
          CMD_SLEEP: state_d = ST_SR_ENTRY;
          CMD_FREQ:  state_d = ST_FC_REQ;
          default:   state_d = ST_ACTIVE;
        endcase
      end
      ST_IDLE:     if (irq_i || wake_i)  state_d = ST_ACTIVE;
      ST_SR_ENTRY: if (mem_ack_i)        state_d = ST_SLEEP;
      ST_SLEEP:    if (wake_i)           state_d = ST_WAKE_RST;
      ST_WAKE_RST: if (stretch_done_i)   state_d = ST_ACTIVE;
      ST_FC_REQ:                         state_d = ST_FC_HOLD;
      ST_FC_HOLD:  if (mem_ack_i)        state_d = ST_FC_APPLY;
      ST_FC_APPLY:                       state_d = ST_FC_LOCK;
      ST_FC_LOCK:  if (pll_locked_i)     state_d = ST_FC_REL;
      ST_FC_REL:                         state_d = ST_ACTIVE;
      default:                           state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ACTIVE;
      turbo_q    <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_cmd_q <= '0;
      cfg_q      <= CFG_RST;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ACTIVE && act_v) begin
        if (act_cmd == CMD_RUN)   turbo_q <= 1'b0;
        if (act_cmd == CMD_TURBO) turbo_q <= 1'b1;
      end
      if (state_q == ST_WAKE_RST && stretch_done_i) turbo_q <= 1'b0;
      if (in_fc && cmd_ok) begin
        pend_v_q   <= 1'b1;
        pend_cmd_q <= req_cmd_i;
      end else if (state_q == ST_ACTIVE || state_q == ST_WAKE_RST) begin
        pend_v_q <= 1'b0;
      end
      if (state_q == ST_FC_APPLY) cfg_q <= cfg_i;
    end
  end

  assign lock_start_o    = (state_q == ST_FC_APPLY);
  assign stretch_start_o = (state_q == ST_SLEEP) && wake_i;

  assign core_clk_en_o = state_q inside {ST_ACTIVE, ST_FC_REQ, ST_FC_HOLD, ST_FC_REL};
  assign mem_hold_o    = state_q inside {ST_FC_HOLD, ST_FC_APPLY, ST_FC_LOCK};
  assign mem_sr_o      = state_q inside {ST_SR_ENTRY, ST_SLEEP, ST_WAKE_RST};
  assign pwr_down_o    = (state_q == ST_SLEEP);
  assign fc_busy_o     = state_q inside {ST_FC_REQ, ST_FC_HOLD, ST_FC_APPLY, ST_FC_LOCK};
  assign turbo_sel_o   = turbo_q;
  assign pll_cfg_o     = cfg_q;

  always_comb begin
    if (state_q == ST_IDLE)
      mode_o = MODE_IDLE;
    else if (state_q inside {ST_SR_ENTRY, ST_SLEEP, ST_WAKE_RST})
      mode_o = MODE_SLEEP;
    else
      mode_o = turbo_q ? MODE_TURBO : MODE_RUN;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int               CFG_W   = 12,
  parameter logic [CFG_W-1:0] CFG_RST = '0,
  parameter int               DLY_W   = 4,
  parameter int               RST_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_cmd_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [DLY_W-1:0] lock_dly_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic             mem_ack_i,
  output logic             core_clk_en_o,
  output logic             turbo_sel_o,
  output logic [1:0]       mode_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic             pll_locked_o,
  output logic             mem_hold_o,
  output logic             mem_sr_o,
  output logic             pwr_down_o,
  output logic             rst_req_o,
  output logic             fc_busy_o
);
  logic lock_start, stretch_start, stretch_done;

  pwr_mode_fsm #(
    .CFG_W  (CFG_W),
    .CFG_RST(CFG_RST)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_cmd_i      (req_cmd_i),
    .cfg_i          (cfg_i),
    .irq_i          (irq_i),
    .wake_i         (wake_i),
    .mem_ack_i      (mem_ack_i),
    .pll_locked_i   (pll_locked_o),
    .stretch_done_i (stretch_done),
    .lock_start_o   (lock_start),
    .stretch_start_o(stretch_start),
    .core_clk_en_o  (core_clk_en_o),
    .turbo_sel_o    (turbo_sel_o),
    .mode_o         (mode_o),
    .pll_cfg_o      (pll_cfg_o),
    .mem_hold_o     (mem_hold_o),
    .mem_sr_o       (mem_sr_o),
    .pwr_down_o     (pwr_down_o),
    .fc_busy_o      (fc_busy_o)
  );

  pll_lock_model #(.DLY_W(DLY_W)) u_pll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lock_start),
    .dly_i   (lock_dly_i),
    .locked_o(pll_locked_o)
  );

  rst_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stretch_start),
    .active_o(rst_req_o),
    .done_o  (stretch_done)
  );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int CFG_W   = 12,
  parameter int RST_CYC = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_ack_i,
  input logic             core_clk_en_o,
  input logic [1:0]       mode_o,
  input logic [CFG_W-1:0] pll_cfg_o,
  input logic             pll_locked_o,
  input logic             mem_hold_o,
  input logic             mem_sr_o,
  input logic             pwr_down_o,
  input logic             rst_req_o,
  input logic             fc_busy_o
);
  localparam logic [15:0] RC = 16'(RST_CYC);
  logic [15:0] rst_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rst_cnt <= '0;
    else if (rst_req_o) rst_cnt <= rst_cnt + 16'd1;
    else                rst_cnt <= '0;
  end

  a_r3_idle_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> !core_clk_en_o);
  a_r4_pwrdn_in_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> mem_sr_o);
  a_r4_pwrdn_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(mem_ack_i));
  a_r5_rst_req_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_cnt < RC));
  a_r5_rst_req_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (rst_cnt == RC));
  a_r6_hold_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hold_o |-> fc_busy_o);
  a_r7_cfg_under_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_cfg_o) |-> (mem_hold_o && !core_clk_en_o && !pll_locked_o));
  a_r8_release_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fc_busy_o) |-> (pll_locked_o && !mem_hold_o));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.CFG_W(CFG_W), .RST_CYC(RST_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_ack_i    (mem_ack_i),
  .core_clk_en_o(core_clk_en_o),
  .mode_o       (mode_o),
  .pll_cfg_o    (pll_cfg_o),
  .pll_locked_o (pll_locked_o),
  .mem_hold_o   (mem_hold_o),
  .mem_sr_o     (mem_sr_o),
  .pwr_down_o   (pwr_down_o),
  .rst_req_o    (rst_req_o),
  .fc_busy_o    (fc_busy_o)
);

// File: tb/pwr_mode_seq_tb.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb;
  localparam int CFG_W = 12;
  localparam int DLY_W = 4;
  localparam int RST_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic [DLY_W-1:0] dly = '0;
  logic irq = 1'b0, wake = 1'b0, ack = 1'b0, ack_en = 1'b1;
  logic core_clk_en, turbo_sel, pll_locked, mem_hold, mem_sr, pwr_down, rst_req, fc_busy;
  logic [1:0] mode;
  logic [CFG_W-1:0] pll_cfg;

  int n_cmp = 0, n_err = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.CFG_W(CFG_W), .DLY_W(DLY_W), .RST_CYC(RST_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .cfg_i(cfg), .lock_dly_i(dly), .irq_i(irq), .wake_i(wake), .mem_ack_i(ack),
    .core_clk_en_o(core_clk_en), .turbo_sel_o(turbo_sel), .mode_o(mode),
    .pll_cfg_o(pll_cfg), .pll_locked_o(pll_locked), .mem_hold_o(mem_hold),
    .mem_sr_o(mem_sr), .pwr_down_o(pwr_down), .rst_req_o(rst_req), .fc_busy_o(fc_busy)
  );

  // memory controller model: acknowledges one cycle after a request when enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_en & (mem_hold | mem_sr);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    req_valid = 1'b1;
    req_cmd   = c;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic do_fc(input int d, input logic [CFG_W-1:0] v, input bit stall, input logic exp_turbo);
    logic [CFG_W-1:0] old_cfg;
    int n;
    old_cfg = pll_cfg;
    dly = DLY_W'(d);
    cfg = v;
    if (stall) ack_en = 1'b0;
    send(3'd4);
    chk("R6 busy after request", fc_busy, 1);
    chk("R6 no hold in request cycle", mem_hold, 0);
    tick();
    chk("R6 hold raised", mem_hold, 1);
    if (stall) begin
      for (int i = 0; i < 5; i++) tick();
      chk("R6 hold kept without ack", mem_hold, 1);
      chk("R6 cfg unchanged without ack", pll_cfg, old_cfg);
      chk("R6 lock unchanged without ack", pll_locked, 1);
      ack_en = 1'b1;
    end
    n = 0;
    while (pll_locked && n < 20) begin n++; tick(); end
    chk("R7 cfg applied", pll_cfg, v);
    chk("R7 core gated in relock", core_clk_en, 0);
    n = 0;
    while (!pll_locked && n < 40) begin n++; tick(); end
    chk("R7 lock low length", n, d + 1);
    chk("R8 busy until after lock", fc_busy, 1);
    tick();
    chk("R8 busy released", fc_busy, 0);
    chk("R8 hold released", mem_hold, 0);
    chk("R8 core clock back", core_clk_en, 1);
    chk("R8 turbo preserved", turbo_sel, exp_turbo);
    tick();
  endtask

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 turbo", turbo_sel, 0);
    chk("R1 mode", mode, 0);
    chk("R1 hold", mem_hold, 0);
    chk("R1 sr", mem_sr, 0);
    chk("R1 pwr_down", pwr_down, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 busy", fc_busy, 0);
    chk("R1 cfg", pll_cfg, 0);
    chk("R1 locked", pll_locked, 1);

    // R2 run/turbo and ignored codes
    send(3'd1);
    chk("R2 turbo set", turbo_sel, 1);
    chk("R2 mode turbo", mode, 1);
    send(3'd0);
    chk("R2 run set", turbo_sel, 0);
    for (int c = 5; c < 8; c++) begin
      send(3'(c));
      chk("R2 bad code mode", mode, 0);
      chk("R2 bad code busy", fc_busy, 0);
      chk("R2 bad code clk", core_clk_en, 1);
    end

    // R3 idle, exit by irq, request during idle ignored
    send(3'd1);
    send(3'd2);
    chk("R3 idle gate", core_clk_en, 0);
    chk("R3 idle mode", mode, 2);
    send(3'd0);
    tick(); tick();
    chk("R3 still idle", core_clk_en, 0);
    irq = 1'b1; tick(); irq = 1'b0;
    chk("R3 irq exit clk", core_clk_en, 1);
    chk("R2 run ignored in idle", mode, 1);
    send(3'd0);
    send(3'd2);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R3 wake exit clk", core_clk_en, 1);
    chk("R3 wake exit mode", mode, 0);

    // R4 sleep entry, R5 wake through reset
    send(3'd1);
    ack_en = 1'b0;
    send(3'd3);
    chk("R4 sr raised", mem_sr, 1);
    chk("R4 mode sleep", mode, 3);
    chk("R4 core gated", core_clk_en, 0);
    repeat (4) tick();
    chk("R4 no pwr_down before ack", pwr_down, 0);
    ack_en = 1'b1;
    n = 0;
    while (!pwr_down && n < 10) begin n++; tick(); end
    chk("R4 pwr_down after ack", pwr_down, 1);
    irq = 1'b1; tick(); irq = 1'b0;
    tick();
    chk("R5 irq no wake", pwr_down, 1);
    chk("R5 no reset on irq", rst_req, 0);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R5 pwr_down dropped", pwr_down, 0);
    n = 0;
    while (rst_req && n < 100) begin n++; tick(); end
    chk("R5 reset length", n, RST_CYC);
    chk("R5 mode run", mode, 0);
    chk("R5 turbo cleared", turbo_sel, 0);
    chk("R5 sr cleared", mem_sr, 0);
    chk("R5 clk back", core_clk_en, 1);

    // R6-R8 sweep over all relock delays
    do_fc(3, 12'hABC, 1'b1, 1'b0);
    for (int d = 0; d < 16; d++) begin
      logic t;
      t = d[0];
      send(t ? 3'd1 : 3'd0);
      do_fc(d, CFG_W'((d * 173 + 29) % 4096), 1'b0, t);
    end

    // R9 held request, later one wins
    send(3'd0);
    dly = 4'd4;
    cfg = 12'h123;
    send(3'd4);
    send(3'd2);
    send(3'd1);
    n = 0;
    while (fc_busy && n < 40) begin n++; tick(); end
    chk("R9 not applied at release", turbo_sel, 0);
    tick();
    chk("R9 not applied one cycle on", turbo_sel, 0);
    tick();
    chk("R9 held turbo applied", turbo_sel, 1);
    chk("R9 earlier idle discarded", mode, 1);
    chk("R9 clk running", core_clk_en, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule